// File: doc/BRIEF.md
# Cross-Domain Snapshot Counter

This block keeps a free-running 64-bit count in a slow reference clock domain and lets software on an APB bus, clocked by an unrelated faster clock, read that count as one coherent value. Software does not read the live count. It sets a request bit in the control word. Hardware carries the request into the reference domain, where all 64 bits are captured on a single edge. Completion is then signalled back to the bus side.

When the acknowledge arrives, the bus side copies the captured value into a low word and a high word and drops the request bit. Software polls the request bit until it reads 0 and then reads the two words, which always belong to the same count. The counter itself has no preload, compare or interrupt. It increments on every reference edge and silently wraps from all-ones to zero.

Top module: `snap_cnt64`

## Requirements
- R1: After reset, the control word, the low word and the high word all read as 0.
- R2: Writing a word with bit 1 set to the control register at offset 0x0 sets the request bit, which then reads back as 1. Writing the control register with bit 1 clear has no effect.
- R3: Once a request write is accepted, the request bit returns to 0 no later than four reference-clock periods plus four bus-clock periods later.
- R4: Each captured 64-bit value lies between the reference edge count seen just before the request and the count seen when the request bit is observed clear.
- R5: The low 32 bits of the capture read at offset 0x4 and the high 32 bits read at offset 0x8.
- R6: Reads of any offset other than 0x0, 0x4 and 0x8 return 0, and every control-word bit other than bit 1 reads as 0.
- R7: The ready output is always 1, so no transfer has wait states.
- R8: A request write while the request bit is already 1 is ignored. It starts no second capture and does not restart the one in progress.
- R9: The counter advances by exactly one on every reference edge, wraps from all-ones to zero with no flag, and successive captures increase.
- R10: The low and high words change only when a capture completes. Bus writes to offsets 0x4 and 0x8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | APB bus clock |
| bus_rst_ni | input | 1 | Bus-domain reset, active low, released synchronously |
| ref_clk_i | input | 1 | Reference clock for the counter |
| ref_rst_ni | input | 1 | Reference-domain reset, active low, released synchronously |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB direction, 1 for write |
| paddr_i | input | 12 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |

## Verification
The bench keeps its own count of reference edges and brackets every capture between the counts seen before the request and after it completes. A counter that skips or stalls, a capture taken from a stale snapshot, or swapped words would all fall outside that window. It fires a second request while the first is still in flight. If the design restarted the handshake, the word would change after completion or the bit would stay high. It also times the busy bit against the four-plus-four period bound, so an extra synchronizer stage or a lost acknowledge shows up as a late clear. Writes to the read-only words and to unmapped offsets, and writes of 0 to the request bit, must leave every readable value unchanged.

// File: rtl/snap_cnt_pkg.sv
`timescale 1ns/1ps
package snap_cnt_pkg;
  localparam int unsigned OFF_CTRL = 32'h0;
  localparam int unsigned OFF_LO   = 32'h4;
  localparam int unsigned OFF_HI   = 32'h8;
  localparam int unsigned REQ_BIT  = 1;
endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/snap_ref_side.sv
`timescale 1ns/1ps
module snap_ref_side #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_tgl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             ack_tgl_o
);
  logic             req_s, req_seen_q, fire;
  logic [CNT_W-1:0] cnt_q, snap_q;
  logic             ack_q;

  cdc_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_tgl_i), .q_o(req_s)
  );

  assign fire = req_s ^ req_seen_q;

  // all bits captured on one edge; snap stays put until next request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      snap_q     <= '0;
      ack_q      <= 1'b0;
      req_seen_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
      req_seen_q <= req_s;
      if (fire) begin
        snap_q <= cnt_q;
        ack_q  <= ~ack_q;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign snap_o    = snap_q;
  assign ack_tgl_o = ack_q;
endmodule

// File: rtl/snap_bus_side.sv
`timescale 1ns/1ps
module snap_bus_side
  import snap_cnt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [CNT_W-1:0]  snap_i,
  input  logic              ack_s_i,
  output logic              req_tgl_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFF_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFF_HI);

  logic              wr_ctrl, done, ack_seen_q, busy_q, req_q;
  logic [DATA_W-1:0] lo_q, hi_q;
  logic              unused_wdata;

  assign unused_wdata = ^pwdata_i;
  assign wr_ctrl = psel_i && penable_i && pwrite_i && (paddr_i == A_CTRL)
                   && pwdata_i[REQ_BIT];
  assign done    = ack_s_i ^ ack_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_seen_q <= 1'b0;
      busy_q     <= 1'b0;
      req_q      <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else begin
      ack_seen_q <= ack_s_i;
      if (done) begin
        lo_q   <= snap_i[DATA_W-1:0];
        hi_q   <= snap_i[CNT_W-1:DATA_W];
        busy_q <= 1'b0;
      end else if (wr_ctrl && !busy_q) begin
        busy_q <= 1'b1;
        req_q  <= ~req_q;
      end
    end
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      unique case (paddr_i)
        A_CTRL:  prdata_o[REQ_BIT] = busy_q;
        A_LO:    prdata_o = lo_q;
        A_HI:    prdata_o = hi_q;
        default: prdata_o = '0;
      endcase
    end
  end

  assign req_tgl_o = req_q;
  assign busy_o    = busy_q;
  assign lo_o      = lo_q;
  assign hi_o      = hi_q;
endmodule

// File: rtl/snap_cnt64.sv
`timescale 1ns/1ps
module snap_cnt64 #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              bus_clk_i,
  input  logic              bus_rst_ni,
  input  logic              ref_clk_i,
  input  logic              ref_rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o
);
  logic              req_tgl, ack_tgl, ack_s, busy;
  logic [CNT_W-1:0]  cnt, snap;
  logic [DATA_W-1:0] lo_w, hi_w;

  snap_ref_side #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_ref (
    .clk_i(ref_clk_i), .rst_ni(ref_rst_ni), .req_tgl_i(req_tgl),
    .cnt_o(cnt), .snap_o(snap), .ack_tgl_o(ack_tgl)
  );

  cdc_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk_i(bus_clk_i), .rst_ni(bus_rst_ni), .d_i(ack_tgl), .q_o(ack_s)
  );

  snap_bus_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i(bus_clk_i), .rst_ni(bus_rst_ni),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
    .snap_i(snap), .ack_s_i(ack_s), .req_tgl_o(req_tgl),
    .busy_o(busy), .lo_o(lo_w), .hi_o(hi_w)
  );

  assign pready_o = 1'b1;
endmodule

// File: rtl/snap_cnt64_chk.sv
`timescale 1ns/1ps
module snap_cnt64_chk
  import snap_cnt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              bus_clk_i,
  input logic              bus_rst_ni,
  input logic              ref_clk_i,
  input logic              ref_rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [DATA_W-1:0] pwdata_i,
  input logic [DATA_W-1:0] prdata_o,
  input logic              ack_s,
  input logic              req_tgl,
  input logic              busy,
  input logic [DATA_W-1:0] lo_w,
  input logic [DATA_W-1:0] hi_w,
  input logic [CNT_W-1:0]  cnt
);
  logic unmapped, req_wr;
  assign unmapped = (paddr_i != ADDR_W'(OFF_CTRL)) && (paddr_i != ADDR_W'(OFF_LO))
                    && (paddr_i != ADDR_W'(OFF_HI));
  assign req_wr = psel_i && penable_i && pwrite_i && (paddr_i == ADDR_W'(OFF_CTRL))
                  && pwdata_i[REQ_BIT];

  p_req_sets_busy_r2: assert property (@(posedge bus_clk_i) disable iff (!bus_rst_ni)
    (req_wr && !busy) |=> (busy && (req_tgl != $past(req_tgl))));

  p_clear_on_ack_r3: assert property (@(posedge bus_clk_i) disable iff (!bus_rst_ni)
    (busy && !$stable(ack_s)) |=> !busy);

  p_unmapped_zero_r6: assert property (@(posedge bus_clk_i) disable iff (!bus_rst_ni)
    (psel_i && !pwrite_i && unmapped) |-> (prdata_o == '0));

  p_ignore_busy_req_r8: assert property (@(posedge bus_clk_i) disable iff (!bus_rst_ni)
    (busy && $stable(ack_s)) |=> $stable(req_tgl));

  p_words_hold_r10: assert property (@(posedge bus_clk_i) disable iff (!bus_rst_ni)
    $stable(ack_s) |=> ($stable(lo_w) && $stable(hi_w)));

  p_count_step_r9: assert property (@(posedge ref_clk_i) disable iff (!ref_rst_ni)
    ref_rst_ni |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

bind snap_cnt64 snap_cnt64_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .bus_clk_i(bus_clk_i), .bus_rst_ni(bus_rst_ni),
  .ref_clk_i(ref_clk_i), .ref_rst_ni(ref_rst_ni),
  .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
  .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
  .ack_s(ack_s), .req_tgl(req_tgl), .busy(busy),
  .lo_w(lo_w), .hi_w(hi_w), .cnt(cnt)
);

// File: tb/snap_cnt64_tb.sv
`timescale 1ns/1ps
module snap_cnt64_tb;
  localparam real BUS_HALF = 2.0;   // 250 MHz
  localparam real REF_HALF = 23.0;  // unrelated reference clock
  localparam real BOUND_NS = 8.0*REF_HALF + 8.0*BUS_HALF + 12.0;

  logic        bus_clk = 0, ref_clk = 0;
  logic        bus_rst_n = 0, ref_rst_n = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;

  int    checks = 0, errors = 0;
  bit    finished = 0;
  longint ref_edges = 0;

  always #(BUS_HALF) bus_clk = ~bus_clk;
  always #(REF_HALF) ref_clk = ~ref_clk;

  // reference model: one count per reference edge after reset release
  always @(posedge ref_clk) if (ref_rst_n) ref_edges <= ref_edges + 1;

  snap_cnt64 u_dut (
    .bus_clk_i(bus_clk), .bus_rst_ni(bus_rst_n),
    .ref_clk_i(ref_clk), .ref_rst_ni(ref_rst_n),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata), .pready_o(pready)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: ready compared on every bus clock
  always @(negedge bus_clk) if (bus_rst_n && !finished) check(pready === 1'b1, "R7 pready", pready, 1);

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge bus_clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge bus_clk); penable = 1;
    @(negedge bus_clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge bus_clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge bus_clk); penable = 1; #0.5; d = prdata;
    @(negedge bus_clk); psel = 0; penable = 0;
  endtask

  task automatic do_latch(input bit second_req, output longint val);
    logic [31:0] r, lo, hi;
    longint lo_b, hi_b;
    realtime t0;
    bit clr = 0;
    lo_b = ref_edges;
    apb_write(12'h0, 32'h2);
    t0 = $realtime;
    if (second_req) apb_write(12'h0, 32'h2);
    apb_read(12'h0, r);
    check(r == 32'h2, "R2 request bit reads 1", r, 2);
    for (int i = 0; i < 200 && !clr; i++) begin
      apb_read(12'h0, r);
      clr = (r == 32'h0);
    end
    check(clr && ($realtime - t0 <= BOUND_NS), "R3 request clears in bound",
          longint'($realtime - t0), longint'(BOUND_NS));
    hi_b = ref_edges;
    apb_read(12'h4, lo);
    apb_read(12'h8, hi);
    val = {hi, lo};
    check(val >= lo_b - 1 && val <= hi_b, "R4 snapshot within window", val, lo_b);
    check(hi == 32'(hi_b >> 32), "R5 high word at 0x8", hi, hi_b >> 32);
  endtask

  initial begin
    logic [31:0] r;
    longint v1, v2, v3;
    #20; @(negedge bus_clk); bus_rst_n = 1;
    @(negedge ref_clk); ref_rst_n = 1;
    repeat (5) @(negedge bus_clk);

    apb_read(12'h0, r); check(r == 0, "R1 ctrl reset", r, 0);
    apb_read(12'h4, r); check(r == 0, "R1 low reset", r, 0);
    apb_read(12'h8, r); check(r == 0, "R1 high reset", r, 0);

    apb_write(12'h0, 32'hFFFF_FFFD);  // bit 1 clear
    apb_read(12'h0, r); check(r == 0, "R2 write without bit 1 ignored", r, 0);
    repeat (60) @(negedge bus_clk);
    apb_read(12'h4, r); check(r == 0, "R2 no capture from zero write", r, 0);

    do_latch(0, v1);
    apb_read(12'h4, r); check(r == v1[31:0], "R5 low word at 0x4", r, v1[31:0]);

    repeat (137) @(negedge bus_clk);
    do_latch(0, v2);
    check(v2 > v1, "R9 successive captures increase", v2, v1);

    // R8: second request while busy
    do_latch(1, v3);
    repeat (150) @(negedge bus_clk);
    apb_read(12'h0, r); check(r == 0, "R8 no second capture (busy)", r, 0);
    apb_read(12'h4, r); check(r == v3[31:0], "R8 word unchanged after extra request", r, v3[31:0]);

    // R10: writes to data words ignored
    apb_write(12'h4, 32'hDEAD_BEEF);
    apb_write(12'h8, 32'hFFFF_FFFF);
    apb_read(12'h4, r); check(r == v3[31:0], "R10 low read-only", r, v3[31:0]);
    apb_read(12'h8, r); check(r == v3[63:32], "R10 high read-only", r, v3[63:32]);

    // R6: unmapped offsets and unused control bits
    apb_read(12'h00C, r); check(r == 0, "R6 offset 0xC", r, 0);
    apb_read(12'h010, r); check(r == 0, "R6 offset 0x10", r, 0);
    apb_read(12'hFFC, r); check(r == 0, "R6 offset 0xFFC", r, 0);
    apb_write(12'h0, 32'hFFFF_FFFF);
    apb_read(12'h0, r); check((r & 32'hFFFF_FFFD) == 0, "R6 unused ctrl bits", r, 0);
    repeat (80) @(negedge bus_clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule